// File: doc/BRIEF.md
# HDLC Receive Frame Collector

This block sits behind an HDLC receiver whose 32-byte receive pool fills from the line. It waits for one of two events. A pool-full event means a whole pool of 32 bytes is ready. A message-end event means the final, possibly short, chunk of a frame is ready, and it comes with a residual byte count and an end-of-frame status byte. For each chunk the collector reads the bytes out of the pool into a frame buffer. It then pulses a release acknowledge so that the receiver can reuse the pool.

At message end the collector checks the status byte. If the frame is valid, it streams the gathered frame out on a valid/ready byte stream, with a last flag on the final byte. If the frame is not valid, it drops it. A chunk that would run past the buffer is not read: the collector releases it with an acknowledge and restarts the frame index. A mode input selects a status format that needs one extra valid-frame bit and carries one trailing status byte in the pool. That byte is read but not delivered.

Top module: `hdlcRxCollect`

## Requirements
- R1: After reset `evReady` is 1, and `outValid`, `ackPulse` and `fifoRdEn` are 0.
- R2: A pool-full event accepted while `evReady` is 1 pops exactly 32 bytes (`fifoRdEn` high for 32 cycles). After the last pop, one `ackPulse` follows, and the bytes join the current frame.
- R3: At a message-end event the chunk length is `msgCount` (5 bits). The value 0 means 32 bytes.
- R4: With `trailerMode`=0 a frame is accepted only when status bit 6 (data overflow) is 0, bit 5 (CRC ok) is 1 and bit 4 (aborted) is 0. Bits 7 and 3..0 are ignored. A rejected frame pops no bytes, gets one `ackPulse` and is not delivered.
- R5: With `trailerMode`=1, status bit 7 (valid frame) must also be 1. The delivered length is the gathered length minus one: the last popped byte is not delivered.
- R6: If the current frame index plus the chunk length is at least MAX_FRAME (default 64), the chunk is not popped. One `ackPulse` is issued and the frame index returns to 0. An index plus length of MAX_FRAME-1 is still accepted.
- R7: A frame whose delivered length would be below 1 produces no output bytes and still gets its `ackPulse`.
- R8: After every message end, whether the frame was delivered or dropped, the next frame starts from buffer position 0.
- R9: A delivered frame appears on `outData` in arrival order, one byte per `outValid`&&`outReady` cycle, with `outLast` only on the final byte. Data and last are held while `outReady` is 0.
- R10: While a chunk or a delivery is in progress, `evReady` is 0 and events are ignored: they cause no pops and no acknowledge.
- R11: Each accepted event produces exactly one single-cycle `ackPulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trailerMode | input | 1 | 1 selects the status format with a valid-frame bit and a trailing status byte |
| evPoolFull | input | 1 | Pool-full event, taken when evReady is 1 |
| evMsgEnd | input | 1 | Message-end event, taken when evReady is 1; wins over evPoolFull |
| msgCount | input | 5 | Residual byte count of the last chunk; 0 means 32 |
| msgStatus | input | 8 | End-of-frame status byte |
| evReady | output | 1 | Collector idle and able to take an event |
| fifoRdEn | output | 1 | Pop one byte from the receive pool |
| fifoRdData | input | 8 | Head byte of the receive pool (first-word fall-through) |
| ackPulse | output | 1 | One-cycle release acknowledge for the current chunk |
| outValid | output | 1 | Frame byte valid |
| outReady | input | 1 | Downstream accepts the byte |
| outData | output | 8 | Frame byte |
| outLast | output | 1 | Marks the final byte of a frame |

## Verification
The hardest case to reach is the overrun path. The frame index has to sit close to the buffer size before a chunk arrives, and that only happens after earlier pool-full chunks are taken without a message end. The stimulus builds it up this way: one pool-full followed by a 31-byte end chunk just fits, and one followed by a 32-byte end chunk overruns. Two pool-full events followed by a short end chunk show that the frame restarts from zero. Events that arrive during a stalled delivery are the second hard case. They are produced by holding `outReady` low during a delivery and pulsing an event, then checking that no pops and no acknowledge follow.

// File: rtl/hdlcRxCollectPkg.sv
package hdlcRxCollectPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_COPY,
    ST_ACK,
    ST_SEND
  } colState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadChunk;
    logic takeByte;
    logic clearIdx;
    logic startSend;
    logic advSend;
  } colStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic overrun;
    logic lastByte;
    logic sendOk;
    logic sendLast;
  } colFlags_t;

endpackage

// File: rtl/hdlcRxCollectPath.sv
module hdlcRxCollectPath
  import hdlcRxCollectPkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int POOL_BYTES = 32,
  parameter int MAX_FRAME  = 64
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          trailerMode,
  input  logic                          evMsgEnd,
  input  logic [$clog2(POOL_BYTES)-1:0] msgCount,
  input  logic [DATA_W-1:0]             fifoRdData,
  input  colStrobe_t                    strobe,
  output colFlags_t                     flags,
  output logic [DATA_W-1:0]             outData
);

  localparam int CNT_W  = $clog2(POOL_BYTES);
  localparam int REM_W  = CNT_W + 1;
  localparam int ADDR_W = $clog2(MAX_FRAME);
  localparam int IDX_W  = $clog2(MAX_FRAME + 1);
  localparam int SUM_W  = IDX_W + 1;

  logic [DATA_W-1:0] frameMem [MAX_FRAME];
  logic [IDX_W-1:0]  idx;
  logic [REM_W-1:0]  chunkLen;
  logic [REM_W-1:0]  remain;
  logic [ADDR_W-1:0] sendPtr;
  logic [IDX_W-1:0]  sendLen;
  logic [REM_W-1:0]  newLen;
  logic [IDX_W-1:0]  frameLen;

  // residual count: zero encodes a full pool
  always_comb begin
    if (!evMsgEnd)
      newLen = REM_W'(POOL_BYTES);
    else if (msgCount == '0)
      newLen = REM_W'(POOL_BYTES);
    else
      newLen = {1'b0, msgCount};
  end

  always_comb begin
    frameLen = trailerMode ? (idx - IDX_W'(1)) : idx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idx      <= '0;
      chunkLen <= '0;
      remain   <= '0;
      sendPtr  <= '0;
      sendLen  <= '0;
    end else begin
      if (strobe.loadChunk) begin
        chunkLen <= newLen;
        remain   <= newLen;
      end
      if (strobe.takeByte) begin
        idx    <= idx + IDX_W'(1);
        remain <= remain - REM_W'(1);
      end
      if (strobe.clearIdx)
        idx <= '0;
      if (strobe.startSend) begin
        sendPtr <= '0;
        sendLen <= frameLen;
      end
      if (strobe.advSend)
        sendPtr <= sendPtr + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.takeByte)
      frameMem[idx[ADDR_W-1:0]] <= fifoRdData;
  end

  always_comb begin
    flags.overrun  = (SUM_W'(idx) + SUM_W'(chunkLen)) >= SUM_W'(MAX_FRAME);
    flags.lastByte = (remain == REM_W'(1));
    flags.sendOk   = trailerMode ? (idx >= IDX_W'(2)) : (idx != '0);
    flags.sendLast = (IDX_W'(sendPtr) == (sendLen - IDX_W'(1)));
    outData        = frameMem[sendPtr];
  end

  AST_READ_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.takeByte |-> (idx < IDX_W'(MAX_FRAME)))
    else $error("byte written past frame buffer"); // R6

  AST_SEND_NONEMPTY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.startSend |=> (sendLen != '0))
    else $error("empty frame started"); // R7

endmodule

// File: rtl/hdlcRxCollectCtrl.sv
module hdlcRxCollectCtrl
  import hdlcRxCollectPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       trailerMode,
  input  logic       evPoolFull,
  input  logic       evMsgEnd,
  input  logic [7:0] msgStatus,
  input  colFlags_t  flags,
  input  logic       outReady,
  output colStrobe_t strobe,
  output logic       evReady,
  output logic       fifoRdEn,
  output logic       ackPulse,
  output logic       outValid,
  output logic       outLast
);

  colState_t state, stateNext;
  logic      endReg, endNext;
  logic      dropReg, dropNext;
  logic      statusOk;

  always_comb begin
    if (trailerMode)
      statusOk = (msgStatus & 8'hF0) == 8'hA0;
    else
      statusOk = (msgStatus & 8'h70) == 8'h20;
  end

  always_comb begin
    stateNext = state;
    endNext   = endReg;
    dropNext  = dropReg;
    strobe    = '0;
    evReady   = 1'b0;
    fifoRdEn  = 1'b0;
    ackPulse  = 1'b0;
    outValid  = 1'b0;
    outLast   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        evReady = 1'b1;
        if (evMsgEnd) begin
          endNext = 1'b1;
          if (statusOk) begin
            dropNext         = 1'b0;
            strobe.loadChunk = 1'b1;
            stateNext        = ST_CHECK;
          end else begin
            dropNext  = 1'b1;
            stateNext = ST_ACK;
          end
        end else if (evPoolFull) begin
          endNext          = 1'b0;
          dropNext         = 1'b0;
          strobe.loadChunk = 1'b1;
          stateNext        = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (flags.overrun) begin
          strobe.clearIdx = 1'b1;
          stateNext       = ST_ACK;
        end else begin
          stateNext = ST_COPY;
        end
      end
      ST_COPY: begin
        fifoRdEn        = 1'b1;
        strobe.takeByte = 1'b1;
        if (flags.lastByte)
          stateNext = ST_ACK;
      end
      ST_ACK: begin
        ackPulse = 1'b1;
        if (!endReg) begin
          stateNext = ST_IDLE;
        end else if (!dropReg && flags.sendOk) begin
          strobe.startSend = 1'b1;
          stateNext        = ST_SEND;
        end else begin
          strobe.clearIdx = 1'b1;
          stateNext       = ST_IDLE;
        end
      end
      ST_SEND: begin
        outValid = 1'b1;
        outLast  = flags.sendLast;
        if (outReady) begin
          strobe.advSend = 1'b1;
          if (flags.sendLast) begin
            strobe.clearIdx = 1'b1;
            stateNext       = ST_IDLE;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      endReg  <= 1'b0;
      dropReg <= 1'b0;
    end else begin
      state   <= stateNext;
      endReg  <= endNext;
      dropReg <= dropNext;
    end
  end

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    ackPulse |=> !ackPulse)
    else $error("acknowledge longer than one cycle"); // R11

  AST_BUSY_WHILE_SEND: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (!evReady && !fifoRdEn))
    else $error("event path open during delivery"); // R10

  AST_LAST_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outLast)))
    else $error("stream dropped while stalled"); // R9

  AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && outLast) |=> evReady)
    else $error("not idle after final byte"); // R8

  AST_NO_READ_AT_ACK: assert property (@(posedge clk) disable iff (!rstN)
    ackPulse |-> !fifoRdEn)
    else $error("pop during acknowledge"); // R2

endmodule

// File: rtl/hdlcRxCollect.sv
module hdlcRxCollect
  import hdlcRxCollectPkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int POOL_BYTES = 32,
  parameter int MAX_FRAME  = 64
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          trailerMode,
  input  logic                          evPoolFull,
  input  logic                          evMsgEnd,
  input  logic [$clog2(POOL_BYTES)-1:0] msgCount,
  input  logic [7:0]                    msgStatus,
  output logic                          evReady,
  output logic                          fifoRdEn,
  input  logic [DATA_W-1:0]             fifoRdData,
  output logic                          ackPulse,
  output logic                          outValid,
  input  logic                          outReady,
  output logic [DATA_W-1:0]             outData,
  output logic                          outLast
);

  colStrobe_t strobe;
  colFlags_t  flags;

  hdlcRxCollectCtrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .trailerMode(trailerMode),
    .evPoolFull (evPoolFull),
    .evMsgEnd   (evMsgEnd),
    .msgStatus  (msgStatus),
    .flags      (flags),
    .outReady   (outReady),
    .strobe     (strobe),
    .evReady    (evReady),
    .fifoRdEn   (fifoRdEn),
    .ackPulse   (ackPulse),
    .outValid   (outValid),
    .outLast    (outLast)
  );

  hdlcRxCollectPath #(
    .DATA_W    (DATA_W),
    .POOL_BYTES(POOL_BYTES),
    .MAX_FRAME (MAX_FRAME)
  ) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .trailerMode(trailerMode),
    .evMsgEnd   (evMsgEnd),
    .msgCount   (msgCount),
    .fifoRdData (fifoRdData),
    .strobe     (strobe),
    .flags      (flags),
    .outData    (outData)
  );

  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> $stable(outData))
    else $error("data changed while stalled"); // R9

endmodule

// File: tb/hdlcRxCollect_test.sv
module hdlcRxCollect_test;

  localparam int MAX_FRAME = 64;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       trailerMode = 1'b0;
  logic       evPoolFull = 1'b0;
  logic       evMsgEnd = 1'b0;
  logic [4:0] msgCount = '0;
  logic [7:0] msgStatus = '0;
  logic       evReady, fifoRdEn, ackPulse, outValid, outLast;
  logic       outReady = 1'b0;
  logic [7:0] fifoRdData, outData;

  logic [7:0] fifoMem [256];
  int         head = 0;
  int         tail = 0;
  int         rdCnt = 0;
  int         ackCnt = 0;
  int         checkCnt = 0;
  int         failCnt = 0;
  logic [8:0] expQ [$];
  logic [7:0] modelFrame [$];
  logic [7:0] seedByte = 8'h11;
  bit         stall = 1'b0;

  always #4 clk = ~clk;

  hdlcRxCollect uut (
    .clk(clk), .rstN(rstN), .trailerMode(trailerMode),
    .evPoolFull(evPoolFull), .evMsgEnd(evMsgEnd),
    .msgCount(msgCount), .msgStatus(msgStatus),
    .evReady(evReady), .fifoRdEn(fifoRdEn), .fifoRdData(fifoRdData),
    .ackPulse(ackPulse), .outValid(outValid), .outReady(outReady),
    .outData(outData), .outLast(outLast)
  );

  assign fifoRdData = fifoMem[head[7:0]];

  // receive pool model: pops on read, releases on acknowledge
  always @(posedge clk) begin
    if (fifoRdEn) begin
      head  <= head + 1;
      rdCnt <= rdCnt + 1;
    end
    if (ackPulse) begin
      head   <= tail;
      ackCnt <= ackCnt + 1;
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: compare each accepted byte with the scoreboard
  always @(negedge clk) begin
    if (rstN && outValid && outReady) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R9 unexpected byte", int'(outData), -1);
      end else begin
        logic [8:0] e;
        e = expQ.pop_front();
        check({outLast, outData} == e, "R9 stream byte",
              int'({outLast, outData}), int'(e));
      end
    end
  end

  // downstream readiness with periodic back-pressure
  initial begin
    int n = 0;
    forever begin
      @(posedge clk);
      #1;
      outReady = !stall && (n % 3 != 2);
      n++;
    end
  end

  function automatic bit modelOk(logic [7:0] s);
    if (trailerMode) return (s & 8'hF0) == 8'hA0;
    return (s & 8'h70) == 8'h20;
  endfunction

  task automatic chunk(bit isEnd, logic [4:0] cnt, logic [7:0] status, string tag);
    int n, expRd, r0, a0, dlen;
    bit ok;
    logic [7:0] bytes [$];
    n = (!isEnd || cnt == 0) ? 32 : int'(cnt);
    for (int i = 0; i < n; i++) begin
      seedByte = seedByte * 8'd5 + 8'd3;
      fifoMem[tail[7:0]] = seedByte;
      tail++;
      bytes.push_back(seedByte);
    end
    ok = isEnd ? modelOk(status) : 1'b1;
    if (!ok) begin
      expRd = 0;
      modelFrame.delete();
    end else if (modelFrame.size() + n >= MAX_FRAME) begin
      expRd = 0;
      modelFrame.delete();
    end else begin
      expRd = n;
      foreach (bytes[i]) modelFrame.push_back(bytes[i]);
    end
    if (isEnd) begin
      dlen = modelFrame.size() - (trailerMode ? 1 : 0);
      if (ok && dlen >= 1)
        for (int i = 0; i < dlen; i++)
          expQ.push_back({(i == dlen - 1), modelFrame[i]});
      modelFrame.delete();
    end
    @(negedge clk);
    while (!evReady) @(negedge clk);
    r0 = rdCnt;
    a0 = ackCnt;
    if (isEnd) evMsgEnd = 1'b1; else evPoolFull = 1'b1;
    msgCount  = cnt;
    msgStatus = status;
    @(negedge clk);
    evMsgEnd   = 1'b0;
    evPoolFull = 1'b0;
    while (!evReady) @(negedge clk);
    check(rdCnt - r0 == expRd, {tag, " pops"}, rdCnt - r0, expRd);
    check(ackCnt - a0 == 1, "R11 one ack per chunk", ackCnt - a0, 1);
    if (isEnd)
      check(expQ.size() == 0, {tag, " delivered all"}, expQ.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(evReady && !outValid && !ackPulse && !fifoRdEn, "R1 reset state",
          int'({evReady, outValid, ackPulse, fifoRdEn}), 8);

    // normal status format
    chunk(1'b1, 5'd5, 8'h20, "R3 short end chunk");
    chunk(1'b1, 5'd3, 8'h2F, "R4 low status bits ignored");
    chunk(1'b1, 5'd0, 8'hA0, "R3 zero count means 32");
    chunk(1'b0, 5'd0, 8'h00, "R2 pool full");
    chunk(1'b1, 5'd10, 8'h20, "R2 frame of pool plus tail");
    chunk(1'b1, 5'd4, 8'h60, "R4 data overflow drops");
    chunk(1'b1, 5'd4, 8'h30, "R4 abort drops");
    chunk(1'b1, 5'd4, 8'h00, "R4 bad crc drops");
    chunk(1'b0, 5'd0, 8'h00, "R8 pool before drop");
    chunk(1'b1, 5'd4, 8'h00, "R8 dropped frame");
    chunk(1'b1, 5'd3, 8'h20, "R8 next frame from zero");
    chunk(1'b0, 5'd0, 8'h00, "R6 pool");
    chunk(1'b1, 5'd31, 8'h20, "R6 63 bytes fit");
    chunk(1'b0, 5'd0, 8'h00, "R6 pool");
    chunk(1'b1, 5'd0, 8'h20, "R6 end overrun");
    chunk(1'b0, 5'd0, 8'h00, "R6 pool");
    chunk(1'b0, 5'd0, 8'h00, "R6 pool overrun");
    chunk(1'b1, 5'd4, 8'h20, "R6 restart after overrun");

    // trailing status byte format
    trailerMode = 1'b1;
    chunk(1'b1, 5'd6, 8'hA0, "R5 trailer stripped");
    chunk(1'b1, 5'd6, 8'h20, "R5 valid bit missing drops");
    chunk(1'b1, 5'd1, 8'hA0, "R7 only trailer byte");
    chunk(1'b1, 5'd2, 8'hA0, "R7 one byte frame");
    chunk(1'b0, 5'd0, 8'h00, "R5 pool");
    chunk(1'b1, 5'd5, 8'hB0, "R5 abort drops");
    trailerMode = 1'b0;

    // events while a delivery is stalled
    stall = 1'b1;
    fork
      chunk(1'b1, 5'd3, 8'h20, "R10 stalled frame");
      begin
        int r0, a0;
        @(negedge clk);
        while (!outValid) @(negedge clk);
        repeat (2) @(negedge clk);
        r0 = rdCnt;
        a0 = ackCnt;
        evPoolFull = 1'b1;
        @(negedge clk);
        evPoolFull = 1'b0;
        repeat (5) @(negedge clk);
        check(rdCnt == r0 && ackCnt == a0, "R10 event ignored while busy",
              rdCnt - r0 + ackCnt - a0, 0);
        check(outValid && !evReady, "R10 delivery held",
              int'({outValid, evReady}), 2);
        stall = 1'b0;
      end
    join
    chunk(1'b1, 5'd7, 8'h20, "R10 frame after stall");

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule